// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block produces the strobe and bus timing that an 8-bit microcontroller core uses to reach memory outside the chip. It runs on the oscillator clock. Every oscillator period is one phase, two phases make one state, and six states make a machine cycle of 12 slots, numbered 0 to 11. The slot count starts at 0 on the first clock after a cycle boundary. Each machine cycle is either a code-fetch cycle or a data-access cycle. The choice is made at the boundary, at the end of slot 11.

A fetch cycle gives two address-latch pulses. When code comes from outside the chip, it also gives two program-read strobe pulses, and the low half of the fetch address is put out twice: first the address as given, then the address plus one. A data cycle gives only one address-latch pulse and no program-read pulses. A data cycle puts the low byte of the data address on the shared bus and then carries the data: write data driven out by the block, or read data sampled from the bus. The high address port carries either the upper address byte or the value held in the high-port register. The access mode and the kind of cycle decide which.

Data requests use a valid/ready channel that is accepted only at a cycle boundary. Read results leave on a valid/ready channel. While a read result is still waiting for its consumer, no new request is accepted. This is the block's back-pressure rule: the bus cannot stall in the middle of a cycle, so a blocked request simply waits and the block runs fetch cycles in the meantime.

Top module: `xmem_cycle_seq`

## Requirements
- R1: Every state lasts two oscillator clocks and a machine cycle lasts 12 clocks. Each address-latch pulse (`ale`, active high) is high for exactly two clocks.
- R2: A fetch cycle gives two `ale` pulses, at slots 1-2 and 7-8, whether code is internal or external. With no data traffic, `ale` therefore runs at one sixth of the clock rate.
- R3: A data cycle gives exactly one `ale` pulse, at slots 1-2. The pulse at slots 7-8 is left out.
- R4: `psen_n` (active low) goes low at slots 4-5 and 10-11 of a fetch cycle when `code_ext`=1, which is two pulses. It stays high in internal fetch cycles and in every data cycle.
- R5: In an external fetch cycle, `ad_out` carries the low byte of the fetch address with `ad_oe`=1 during slots 0-3. It carries the low byte of the fetch address plus one during slots 6-9. `ad_oe`=0 while `psen_n` is low.
- R6: `a_hi` carries the upper address byte in external fetch cycles (the address plus one in the second half) and in 16-bit data accesses (`req_wide`=1). It carries `p2_reg` in 8-bit data accesses and in internal fetch cycles.
- R7: A write (`req_write`=1) drives `ad_out`=`req_wdata` with `ad_oe`=1 from slot 4 through slot 11. `wr_n` is low for slots 5-10 only.
- R8: A read holds `rd_n` low for slots 5-10 and keeps `ad_oe`=0 from slot 4 through slot 11. It samples `ad_in` at the end of slot 10 and raises `rsp_valid` with that byte on `rsp_data` from slot 11.
- R9: `rd_n` and `wr_n` are never low together and never low in a fetch cycle. While either one is low, `ale` is 0 and `psen_n` is 1.
- R10: `req_ready` can be high only in slot 11. A request taken there makes the next machine cycle a data cycle. With no request taken, the next machine cycle is a fetch of `fetch_addr`.
- R11: While `rsp_valid`=1 and `rsp_ready`=0, the response and its data are held and `req_ready` stays 0. A request presented then is not taken, and fetch cycles run instead.
- R12: While `rst` is high: `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `ad_oe`=0, `rsp_valid`=0 and `req_ready`=0. After release, the block is in slot 11 and the first boundary comes on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| code_ext | input | 1 | Code is fetched from external memory |
| fetch_addr | input | 16 | Address for the next fetch cycle |
| p2_reg | input | 8 | High-port register value |
| req_valid | input | 1 | Data request valid |
| req_ready | output | 1 | Data request accepted (slot 11 only) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit address, 0 = 8-bit address |
| req_addr | input | 16 | Data address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 8 | Read data |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Multiplexed low address / data out |
| ad_oe | output | 1 | Output enable for the multiplexed bus |
| ad_in | input | 8 | Multiplexed bus input |
| a_hi | output | 8 | High address port |

## Verification
The hardest situation to reach from the ports is a request that arrives while an earlier read result is still waiting. To get there, the stimulus first holds `rsp_ready` low through a read. It then offers a write at the next boundary and checks two things: the write is refused, and a full fetch cycle runs in its place, with two `ale` and two `psen_n` pulses. Only after that does the stimulus release the consumer and check that the same write is taken at once. The pulse counts are gathered over a mixed sequence of internal fetches, external fetches, reads and writes. The skipped `ale` pulses are then checked against the number of data cycles.

// File: rtl/xmem_seq_pkg.sv
package xmem_seq_pkg;
  localparam int PHASES     = 2;
  localparam int STATES     = 6;
  localparam int SLOTS      = STATES * PHASES;
  localparam int HALF_SLOTS = SLOTS / 2;
  localparam int SLOT_W     = $clog2(SLOTS);

  typedef logic [SLOT_W-1:0] slot_t;

  localparam slot_t LAST_SLOT   = slot_t'(SLOTS - 1);
  localparam int    ALE_OFS     = 1;   // latch pulse offset inside a half cycle
  localparam int    PSEN_OFS    = 4;   // program strobe offset inside a half cycle
  localparam int    ADDR_LAST   = 3;   // last slot of an address phase (half-relative)
  localparam slot_t DRIVE_FIRST = slot_t'(4);
  localparam slot_t RW_FIRST    = slot_t'(5);
  localparam slot_t RW_LAST     = slot_t'(10);
  localparam slot_t SAMPLE_SLOT = slot_t'(10);

  typedef enum logic {CYC_FETCH = 1'b0, CYC_DATA = 1'b1} cyc_kind_e;
endpackage

// File: rtl/xmem_slot_timer.sv
module xmem_slot_timer
  import xmem_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output slot_t slot,
  output logic  boundary
);
  localparam int ST_W = $clog2(STATES);
  localparam logic [ST_W-1:0] ST_LAST = ST_W'(STATES - 1);

  logic [ST_W-1:0] state_q;
  logic            phase_q;

  // the phase flop divides the oscillator by two; only rising edges are used
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_LAST;
      phase_q <= 1'b1;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) begin
        if (state_q == ST_LAST) state_q <= '0;
        else                    state_q <= state_q + 1'b1;
      end
    end
  end

  assign slot     = slot_t'({state_q, phase_q});
  assign boundary = (slot == LAST_SLOT);
endmodule

// File: rtl/xmem_cycle_ctl.sv
module xmem_cycle_ctl
  import xmem_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  slot_t             slot,
  input  logic              boundary,
  input  logic              code_ext,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [DATA_W-1:0] ad_in,
  output cyc_kind_e         kind_q,
  output logic              ext_q,
  output logic              write_q,
  output logic              wide_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  logic take;
  logic rsp_stalled;

  assign rsp_stalled = rsp_valid && !rsp_ready;
  assign req_ready   = boundary && !rst && !rsp_stalled;
  assign take        = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q  <= CYC_FETCH;
      ext_q   <= 1'b0;
      write_q <= 1'b0;
      wide_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (boundary) begin
      ext_q <= code_ext;
      if (take) begin
        kind_q  <= CYC_DATA;
        write_q <= req_write;
        wide_q  <= req_wide;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end else begin
        kind_q  <= CYC_FETCH;
        write_q <= 1'b0;
        wide_q  <= 1'b0;
        addr_q  <= fetch_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (kind_q == CYC_DATA && !write_q && slot == SAMPLE_SLOT) begin
        rsp_valid <= 1'b1;
        rsp_data  <= ad_in;
      end
    end
  end
endmodule

// File: rtl/xmem_strobe_gen.sv
module xmem_strobe_gen
  import xmem_seq_pkg::*;
(
  input  slot_t     slot,
  input  cyc_kind_e kind,
  input  logic      ext,
  input  logic      write,
  output logic      ale,
  output logic      psen_n,
  output logic      rd_n,
  output logic      wr_n
);
  logic [1:0] ale_win;
  logic [1:0] psen_win;
  logic       rw_win;

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam slot_t A0 = slot_t'(h * HALF_SLOTS + ALE_OFS);
    localparam slot_t A1 = slot_t'(h * HALF_SLOTS + ALE_OFS + 1);
    localparam slot_t P0 = slot_t'(h * HALF_SLOTS + PSEN_OFS);
    localparam slot_t P1 = slot_t'(h * HALF_SLOTS + PSEN_OFS + 1);
    assign ale_win[h]  = (slot == A0) || (slot == A1);
    assign psen_win[h] = (slot == P0) || (slot == P1);
  end

  assign rw_win = (slot >= RW_FIRST) && (slot <= RW_LAST);

  always_comb begin
    ale    = 1'b0;
    psen_n = 1'b1;
    rd_n   = 1'b1;
    wr_n   = 1'b1;
    if (kind == CYC_FETCH) begin
      ale    = |ale_win;
      psen_n = !(ext && (|psen_win));
    end else begin
      ale  = ale_win[0];
      rd_n = !(!write && rw_win);
      wr_n = !(write && rw_win);
    end
  end
endmodule

// File: rtl/xmem_bus_drive.sv
module xmem_bus_drive
  import xmem_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  slot_t                    slot,
  input  cyc_kind_e                kind,
  input  logic                     ext,
  input  logic                     write,
  input  logic                     wide,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [ADDR_W-DATA_W-1:0] p2_reg,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addr_inc;
  logic [ADDR_W-1:0] cur_addr;
  logic              second_half;
  slot_t             rel_slot;
  logic              addr_phase;

  assign addr_inc    = addr + 1'b1;
  assign second_half = (slot >= slot_t'(HALF_SLOTS));
  assign rel_slot    = second_half ? slot - slot_t'(HALF_SLOTS) : slot;
  assign addr_phase  = (rel_slot <= slot_t'(ADDR_LAST));
  assign cur_addr    = second_half ? addr_inc : addr;

  always_comb begin
    ad_out = '0;
    ad_oe  = 1'b0;
    a_hi   = p2_reg;
    if (kind == CYC_FETCH) begin
      if (ext) begin
        ad_oe  = addr_phase;
        ad_out = cur_addr[DATA_W-1:0];
        a_hi   = cur_addr[ADDR_W-1 -: HI_W];
      end
    end else begin
      if (wide) a_hi = addr[ADDR_W-1 -: HI_W];
      if (!second_half && addr_phase) begin
        ad_oe  = 1'b1;
        ad_out = addr[DATA_W-1:0];
      end else if (write && slot >= DRIVE_FIRST) begin
        ad_oe  = 1'b1;
        ad_out = wdata;
      end
    end
  end
endmodule

// File: rtl/xmem_cycle_seq.sv
module xmem_cycle_seq
  import xmem_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     code_ext,
  input  logic [ADDR_W-1:0]        fetch_addr,
  input  logic [ADDR_W-DATA_W-1:0] p2_reg,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic                     req_wide,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [DATA_W-1:0]        rsp_data,
  output logic                     ale,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] a_hi
);
  slot_t             slot;
  logic              boundary;
  cyc_kind_e         kind_q;
  logic              ext_q;
  logic              write_q;
  logic              wide_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  xmem_slot_timer u_timer (
    .clk      (clk),
    .rst      (rst),
    .slot     (slot),
    .boundary (boundary)
  );

  xmem_cycle_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .slot       (slot),
    .boundary   (boundary),
    .code_ext   (code_ext),
    .fetch_addr (fetch_addr),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_wide   (req_wide),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_data   (rsp_data),
    .ad_in      (ad_in),
    .kind_q     (kind_q),
    .ext_q      (ext_q),
    .write_q    (write_q),
    .wide_q     (wide_q),
    .addr_q     (addr_q),
    .wdata_q    (wdata_q)
  );

  xmem_strobe_gen u_strobe (
    .slot   (slot),
    .kind   (kind_q),
    .ext    (ext_q),
    .write  (write_q),
    .ale    (ale),
    .psen_n (psen_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n)
  );

  xmem_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .slot   (slot),
    .kind   (kind_q),
    .ext    (ext_q),
    .write  (write_q),
    .wide   (wide_q),
    .addr   (addr_q),
    .wdata  (wdata_q),
    .p2_reg (p2_reg),
    .ad_out (ad_out),
    .ad_oe  (ad_oe),
    .a_hi   (a_hi)
  );
endmodule

// File: rtl/xmem_cycle_seq_chk.sv
module xmem_cycle_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ale,
  input logic              psen_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              ad_oe,
  input logic [DATA_W-1:0] ad_out,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              req_ready
);
  // R1: a latch pulse stays high for exactly two clocks
  a_r1_ale_rise_holds: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> ale);
  a_r1_ale_ends: assert property (@(posedge clk) disable iff (rst)
    (ale && $past(ale)) |=> !ale);

  // R9: data strobes exclusive, and no latch or program strobe during them
  a_r9_rw_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  a_r9_quiet_during_rw: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> (!ale && psen_n));

  // R5: bus released while the program strobe is low
  a_r5_psen_releases_bus: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> !ad_oe);

  // R8: bus released during a read strobe
  a_r8_read_releases_bus: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe);

  // R7: write data set up before, held through and after the strobe
  a_r7_wdata_setup: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n) |-> (ad_oe && $past(ad_oe)));
  a_r7_wdata_stable: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && $past(!wr_n)) |-> (ad_oe && $stable(ad_out)));
  a_r7_wdata_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |-> (ad_oe && $stable(ad_out)));

  // R11: a stalled response is held unchanged and blocks new requests
  a_r11_rsp_held: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  a_r11_no_ready_when_stalled: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind xmem_cycle_seq xmem_cycle_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ale       (ale),
  .psen_n    (psen_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .ad_oe     (ad_oe),
  .ad_out    (ad_out),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .req_ready (req_ready)
);

// File: tb/xmem_cycle_seq_test.sv
module xmem_cycle_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  typedef struct packed {
    logic        ext;
    logic        dreq;
    logic        wr;
    logic        wide;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [7:0]  rd;
    logic [7:0]  p2;
    logic [3:0]  exp_ale;
    logic [3:0]  exp_psen;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'h1234, 8'h00, 8'h00, 8'h11, 4'd2, 4'd2},
    '{1'b1, 1'b1, 1'b0, 1'b1, 16'hBEEF, 8'h00, 8'h5A, 8'h22, 4'd1, 4'd0},
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'h12FF, 8'h00, 8'h00, 8'h33, 4'd2, 4'd2},
    '{1'b1, 1'b1, 1'b1, 1'b0, 16'h0077, 8'hC3, 8'h00, 8'hA5, 4'd1, 4'd0},
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'h4321, 8'h00, 8'h00, 8'h6B, 4'd2, 4'd0},
    '{1'b0, 1'b1, 1'b1, 1'b1, 16'h8001, 8'h3C, 8'h00, 8'h44, 4'd1, 4'd0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'h4410, 8'h00, 8'hE7, 8'h9E, 4'd1, 4'd0},
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF, 8'h00, 8'h00, 8'h55, 4'd2, 4'd2}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        code_ext = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic [7:0]  p2_reg = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_wide = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic        ale, psen_n, rd_n, wr_n, ad_oe;
  logic [7:0]  ad_out;
  logic [7:0]  ad_in = '0;
  logic [7:0]  a_hi;

  int tests = 0;
  int fails = 0;
  int total_ale = 0;
  int data_cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xmem_cycle_seq uut (
    .clk(clk), .rst(rst), .code_ext(code_ext), .fetch_addr(fetch_addr),
    .p2_reg(p2_reg), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Runs one machine cycle; called while the design sits in slot 11.
  task automatic run_cycle(input vec_t v, input bit exp_acc);
    bit data;
    logic pa, pp;
    int ale_n, psen_n_cnt, ale_hi, psen_lo, rd_lo, wr_lo;
    bit clash;
    logic [15:0] inc;
    logic [7:0] exp_hi;
    code_ext = v.ext; p2_reg = v.p2; fetch_addr = v.addr;
    req_valid = v.dreq; req_write = v.wr; req_wide = v.wide;
    req_addr = v.addr; req_wdata = v.wd; ad_in = v.rd;
    #1;
    if (v.dreq) check(req_ready == exp_acc, "R10 req_ready at slot 11", req_ready, exp_acc);
    data = v.dreq && exp_acc;
    inc = v.addr + 16'd1;
    pa = ale; pp = psen_n;
    ale_n = 0; psen_n_cnt = 0; ale_hi = 0; psen_lo = 0; rd_lo = 0; wr_lo = 0; clash = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      if (ale && !pa) ale_n++;
      if (!psen_n && pp) psen_n_cnt++;
      if (ale) ale_hi++;
      if (!psen_n) psen_lo++;
      if (!rd_n) rd_lo++;
      if (!wr_n) wr_lo++;
      if ((!rd_n || !wr_n) && (!(rd_n || wr_n) || ale || !psen_n)) clash = 1;
      pa = ale; pp = psen_n;
      if (k == 1) begin
        check(ad_oe == (data || v.ext), "R5 address drive at slot 1", ad_oe, data || v.ext);
        if (data || v.ext) check(ad_out == v.addr[7:0], "R5 low address at slot 1", ad_out, v.addr[7:0]);
        exp_hi = data ? (v.wide ? v.addr[15:8] : v.p2) : (v.ext ? v.addr[15:8] : v.p2);
        check(a_hi == exp_hi, "R6 high port at slot 1", a_hi, exp_hi);
      end
      if (!data && v.ext && k == 4)
        check(ad_oe == 1'b0, "R5 bus released during psen", ad_oe, 0);
      if (!data && v.ext && k == 7) begin
        check(ad_out == inc[7:0] && ad_oe, "R5 second fetch address", ad_out, inc[7:0]);
        check(a_hi == inc[15:8], "R6 second fetch high byte", a_hi, inc[15:8]);
      end
      if (data && v.wr && k == 4)
        check(ad_oe && ad_out == v.wd, "R7 write data before strobe", ad_out, v.wd);
      if (data && v.wr && k == 6)
        check(ad_oe && ad_out == v.wd, "R7 write data on bus", ad_out, v.wd);
      if (data && !v.wr && k == 6)
        check(ad_oe == 1'b0, "R8 bus released in read", ad_oe, 0);
      if (data && !v.wr && k == 11)
        check(rsp_valid && rsp_data == v.rd, "R8 read response", rsp_data, v.rd);
    end
    check(ale_n == int'(v.exp_ale), data ? "R3 ale pulses in data cycle" : "R2 ale pulses in fetch cycle", ale_n, v.exp_ale);
    check(ale_hi == 2 * ale_n, "R1 ale width two clocks each", ale_hi, 2 * ale_n);
    check(psen_n_cnt == int'(v.exp_psen), "R4 psen pulses", psen_n_cnt, v.exp_psen);
    check(psen_lo == 2 * psen_n_cnt, "R1 psen width two clocks each", psen_lo, 2 * psen_n_cnt);
    check(rd_lo == ((data && !v.wr) ? 6 : 0), "R8 rd_n low slots", rd_lo, (data && !v.wr) ? 6 : 0);
    check(wr_lo == ((data && v.wr) ? 6 : 0), "R7 wr_n low slots", wr_lo, (data && v.wr) ? 6 : 0);
    check(!clash, "R9 strobe exclusivity", clash, 0);
    total_ale += ale_n;
    if (data) data_cycles++;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    vec_t v;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(ale == 0 && psen_n && rd_n && wr_n && !ad_oe, "R12 strobes idle in reset",
          {ale, psen_n, rd_n, wr_n, ad_oe}, 5'b01110);
    check(!rsp_valid && !req_ready, "R12 channels idle in reset", {rsp_valid, req_ready}, 0);
    rst = 1'b0;
    #1;
    check(req_ready == 1'b1, "R12 slot 11 after release", req_ready, 1);

    // mixed table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NVEC; i++) run_cycle(VECS[i], 1'b1);
    check(total_ale == 2 * NVEC - data_cycles, "R3 skipped ale equals data cycles",
          2 * NVEC - total_ale, data_cycles);

    // R11 back-pressure: read with stalled consumer
    rsp_ready = 1'b0;
    v = '{1'b1, 1'b1, 1'b0, 1'b1, 16'h2222, 8'h00, 8'h99, 8'h10, 4'd1, 4'd0};
    run_cycle(v, 1'b1);
    v = '{1'b1, 1'b1, 1'b1, 1'b1, 16'h3456, 8'hAB, 8'h99, 8'h20, 4'd2, 4'd2};
    run_cycle(v, 1'b0);   // refused, runs as a fetch
    check(rsp_valid && rsp_data == 8'h99, "R11 response held while stalled", rsp_data, 8'h99);
    rsp_ready = 1'b1;
    v.exp_ale = 4'd1; v.exp_psen = 4'd0;
    run_cycle(v, 1'b1);   // same write now taken
    check(!rsp_valid, "R11 response delivered", rsp_valid, 0);

    // R10 no request: internal fetch at boundary
    v = '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0F0F, 8'h00, 8'h00, 8'h77, 4'd2, 4'd0};
    run_cycle(v, 1'b1);

    // R12 reset mid-cycle
    req_valid = 1'b1; req_write = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(ale == 0 && psen_n && rd_n && wr_n && !ad_oe && !req_ready, "R12 mid-cycle reset",
          {ale, psen_n, rd_n, wr_n, ad_oe}, 5'b01110);
    req_valid = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule